// File: doc/BRIEF.md
# Composite Sync Separator with Burst Gate

This block sits at the front of a video encoder's timing path. It merges a horizontal and a vertical sync input into one composite sync. That sync is sampled on a clock running at twice the colour subcarrier. The block then times each low-going sync pulse in sample clocks. A pulse whose width falls inside a per-standard window counts as a line sync. Narrower pulses are treated as equalizing pulses. Pulses that stay low long enough are broad (serration) pulses, and they mark the vertical interval.

After each line sync, and only outside the vertical interval, the block opens a burst gate. The gate opens a fixed number of samples after the sync's falling edge and stays open for a width that depends on the standard. A one-sample clamp strobe marks each sync falling edge so that the analog path can restore the black level. The vertical-interval flag rises on a broad pulse. It drops again after a run of consecutive line syncs. The standard input selects between two sets of timing constants, one for the 525-line standard and one for the 625-line standard.

Top module: `csync_burst_gate`

## Requirements
- R1: The composite sync is the XNOR of `hsync_in` and `vsync_in`. With `vsync_in` held high, a composite sync on `hsync_in` passes through unchanged; with `vsync_in` low, it is inverted. The input is registered twice, so `csync_out` follows the XNOR two sample clocks later and stays low for exactly as many cycles as the input was low.
- R2: `clamp_strobe` is high for exactly one cycle, in the first cycle in which `csync_out` is low after being high. It is only issued when `vblank` was low before that pulse began.
- R3: A low pulse of W samples is a line sync when HS_MIN <= W <= HS_MAX. With the defaults, the window is 28..37 for the 525-line standard and 35..46 for the 625-line standard. Any other width is not a line sync.
- R4: The burst gate opens only after a line sync and only when `vblank` is low. It never opens after an equalizing pulse, a mid-width pulse or a broad pulse.
- R5: When the burst gate opens, it rises BST_START cycles after the first low cycle of `csync_out` (default 38 for 525-line, 47 for 625-line). It stays high for BST_LEN cycles (default 18 for 525-line, 20 for 625-line).
- R6: `vblank` is set when a low pulse reaches BROAD_MIN samples (default 179 for 525-line, 221 for 625-line). It becomes visible BROAD_MIN cycles after the first low cycle of `csync_out`. Shorter pulses never set it.
- R7: `vblank` clears after VB_CLEAR (default 4) consecutive line syncs. It drops in the cycle in which `csync_out` returns high after the last of them, and that sync receives a burst. Any pulse that is not a line sync restarts the count.
- R8: `std_ntsc` high selects the 525-line timing set; low selects the 625-line set.
- R9: During and after reset, `csync_out` is high and `burst_gate`, `clamp_strobe` and `vblank` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at twice the subcarrier frequency |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, or full composite sync, active low |
| vsync_in | input | 1 | Vertical sync; tie high when hsync_in carries composite sync |
| std_ntsc | input | 1 | 1 selects 525-line timing, 0 selects 625-line timing |
| csync_out | output | 1 | Registered composite sync |
| burst_gate | output | 1 | High while the colour burst is to be inserted |
| clamp_strobe | output | 1 | One-cycle black-level clamp strobe at sync fall |
| vblank | output | 1 | High during the vertical interval |

## Verification
The assertions check several properties on every cycle. The clamp strobe must last a single cycle and coincide with a sync fall. The burst gate must never open while the vertical flag is set or while the sync is still low. The vertical flag may only rise during a low pulse and only fall on a line sync. The exact position and length of the burst, and the width boundaries of the classifier, can only be shown by the bench. So can the consecutive-sync count that ends the vertical interval and the switch between the two timing sets. The bench shows these by driving pulses of chosen widths, in both sync polarities, and comparing every cycle against a per-pulse prediction.

// File: rtl/csbg_pkg.sv
package csbg_pkg;
  localparam int TW = 12;

  typedef struct packed {
    logic [TW-1:0] hs_min;
    logic [TW-1:0] hs_max;
    logic [TW-1:0] bst_start;
    logic [TW-1:0] bst_len;
    logic [TW-1:0] broad_min;
  } line_timing_t;
endpackage

// File: rtl/csbg_sync_in.sv
module csbg_sync_in (
  input  logic clk,
  input  logic rst,
  input  logic hsync_in,
  input  logic vsync_in,
  output logic sync_q,
  output logic fall_evt,
  output logic rise_evt
);
  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      s1     <= ~(hsync_in ^ vsync_in);
      sync_q <= s1;
    end
  end

  assign fall_evt = sync_q & ~s1;
  assign rise_evt = ~sync_q & s1;

  // R1: a detected fall is followed by a low registered sync
  a_r1_fall_goes_low: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !sync_q);
endmodule

// File: rtl/csbg_width_meter.sv
module csbg_width_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_q,
  input  logic          fall_evt,
  input  logic          rise_evt,
  input  logic [CW-1:0] hs_min,
  input  logic [CW-1:0] hs_max,
  input  logic [CW-1:0] broad_min,
  output logic [CW-1:0] since_fall,
  output logic          hs_ok_evt,
  output logic          hs_bad_evt,
  output logic          broad_evt
);
  localparam logic [CW-1:0] SAT = '1;
  logic [CW-1:0] low_cnt;
  logic          in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      since_fall <= SAT;
    end else if (fall_evt) begin
      low_cnt    <= CW'(1);
      since_fall <= CW'(1);
    end else begin
      if (!sync_q && low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
      if (since_fall != SAT) since_fall <= since_fall + 1'b1;
    end
  end

  assign in_window  = (low_cnt >= hs_min) && (low_cnt <= hs_max);
  assign hs_ok_evt  = rise_evt & in_window;
  assign hs_bad_evt = rise_evt & ~in_window;
  assign broad_evt  = ~sync_q & (low_cnt == broad_min);

  // R3: a pulse ending is never both a line sync and a broad detection
  a_r3_ok_not_broad: assert property (@(posedge clk) disable iff (rst)
    hs_ok_evt |-> !broad_evt);
endmodule

// File: rtl/csbg_vblank_ctl.sv
module csbg_vblank_ctl #(
  parameter int VB_CLEAR = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic broad_evt,
  input  logic hs_ok_evt,
  input  logic hs_bad_evt,
  output logic vblank
);
  localparam int VW = (VB_CLEAR < 2) ? 1 : $clog2(VB_CLEAR);
  localparam logic [VW-1:0] LAST = VW'(VB_CLEAR - 1);
  logic [VW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      vblank <= 1'b0;
      run    <= '0;
    end else if (broad_evt) begin
      vblank <= 1'b1;
      run    <= '0;
    end else if (vblank) begin
      if (hs_ok_evt) begin
        if (run == LAST) begin
          vblank <= 1'b0;
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else if (hs_bad_evt) begin
        run <= '0;
      end
    end
  end

  // R7: the flag only drops on a line sync
  a_r7_clear_on_hsync: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank) |-> $past(hs_ok_evt));
endmodule

// File: rtl/csbg_burst_gen.sv
module csbg_burst_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_evt,
  input  logic          hs_ok_evt,
  input  logic          vblank,
  input  logic [CW-1:0] since_fall,
  input  logic [CW-1:0] bst_start,
  input  logic [CW-1:0] bst_len,
  output logic          burst_gate
);
  logic          armed;
  logic          start;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (fall_evt)  armed <= 1'b0;
    else if (hs_ok_evt) armed <= 1'b1;
  end

  assign start = armed & ~vblank & (since_fall == bst_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_gate <= 1'b0;
      bcnt       <= '0;
    end else if (start) begin
      burst_gate <= 1'b1;
      bcnt       <= bst_len - 1'b1;
    end else if (burst_gate) begin
      if (bcnt == '0) burst_gate <= 1'b0;
      else            bcnt       <= bcnt - 1'b1;
    end
  end

  // R4: no burst opens during the vertical interval
  a_r4_no_burst_in_vblank: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_gate) |-> $past(!vblank));
  // R5: a burst lasts more than one sample
  a_r5_burst_min_len: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_gate) |=> burst_gate);
endmodule

// File: rtl/csync_burst_gate.sv
module csync_burst_gate
  import csbg_pkg::*;
#(
  parameter int NT_HS_MIN    = 28,
  parameter int NT_HS_MAX    = 37,
  parameter int NT_BST_START = 38,
  parameter int NT_BST_LEN   = 18,
  parameter int NT_BROAD_MIN = 179,
  parameter int PL_HS_MIN    = 35,
  parameter int PL_HS_MAX    = 46,
  parameter int PL_BST_START = 47,
  parameter int PL_BST_LEN   = 20,
  parameter int PL_BROAD_MIN = 221,
  parameter int VB_CLEAR     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic std_ntsc,
  output logic csync_out,
  output logic burst_gate,
  output logic clamp_strobe,
  output logic vblank
);
  localparam int BROAD_MAX = (NT_BROAD_MIN > PL_BROAD_MIN) ? NT_BROAD_MIN : PL_BROAD_MIN;
  localparam int CW = $clog2(BROAD_MAX + 2);

  localparam line_timing_t NT_TIM = '{hs_min: TW'(NT_HS_MIN), hs_max: TW'(NT_HS_MAX),
    bst_start: TW'(NT_BST_START), bst_len: TW'(NT_BST_LEN), broad_min: TW'(NT_BROAD_MIN)};
  localparam line_timing_t PL_TIM = '{hs_min: TW'(PL_HS_MIN), hs_max: TW'(PL_HS_MAX),
    bst_start: TW'(PL_BST_START), bst_len: TW'(PL_BST_LEN), broad_min: TW'(PL_BROAD_MIN)};

  line_timing_t  tim;
  logic          sync_q, fall_evt, rise_evt;
  logic [CW-1:0] since_fall;
  logic          hs_ok_evt, hs_bad_evt, broad_evt;

  always_comb tim = std_ntsc ? NT_TIM : PL_TIM;

  csbg_sync_in u_sync (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .sync_q(sync_q), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  csbg_width_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst(rst), .sync_q(sync_q), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .hs_min(tim.hs_min[CW-1:0]), .hs_max(tim.hs_max[CW-1:0]),
    .broad_min(tim.broad_min[CW-1:0]), .since_fall(since_fall),
    .hs_ok_evt(hs_ok_evt), .hs_bad_evt(hs_bad_evt), .broad_evt(broad_evt)
  );

  csbg_vblank_ctl #(.VB_CLEAR(VB_CLEAR)) u_vb (
    .clk(clk), .rst(rst), .broad_evt(broad_evt), .hs_ok_evt(hs_ok_evt),
    .hs_bad_evt(hs_bad_evt), .vblank(vblank)
  );

  csbg_burst_gen #(.CW(CW)) u_burst (
    .clk(clk), .rst(rst), .fall_evt(fall_evt), .hs_ok_evt(hs_ok_evt), .vblank(vblank),
    .since_fall(since_fall), .bst_start(tim.bst_start[CW-1:0]),
    .bst_len(tim.bst_len[CW-1:0]), .burst_gate(burst_gate)
  );

  always_ff @(posedge clk) begin
    if (rst) clamp_strobe <= 1'b0;
    else     clamp_strobe <= fall_evt & ~vblank;
  end

  assign csync_out = sync_q;

  initial begin
    a_cfg_order: assert (NT_BST_START > NT_HS_MAX && PL_BST_START > PL_HS_MAX
                         && NT_BST_LEN >= 2 && PL_BST_LEN >= 2 && CW <= TW && VB_CLEAR >= 1)
      else $error("csync_burst_gate: inconsistent timing parameters");
  end

  // R2: the strobe marks a sync fall and lasts one cycle
  a_r2_clamp_at_fall: assert property (@(posedge clk) disable iff (rst)
    clamp_strobe |-> (!csync_out && $past(csync_out)));
  a_r2_clamp_single: assert property (@(posedge clk) disable iff (rst)
    clamp_strobe |=> !clamp_strobe);
  // R5: the burst opens only after the sync has returned high
  a_r5_burst_after_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_gate) |-> csync_out);
  // R6: the vertical flag rises only during a low pulse
  a_r6_vblank_in_low: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> $past(!csync_out));
endmodule

// File: tb/csync_burst_gate_bench.sv
module csync_burst_gate_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b1, vsync_in = 1'b1, std_ntsc = 1'b1;
  logic csync_out, burst_gate, clamp_strobe, vblank;

  int checks = 0;
  int errors = 0;
  bit vb_m = 1'b0;
  int run_m = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csync_burst_gate u_csync_burst_gate (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in), .std_ntsc(std_ntsc),
    .csync_out(csync_out), .burst_gate(burst_gate), .clamp_strobe(clamp_strobe), .vblank(vblank)
  );

  function automatic int t_hmin();  return std_ntsc ? 28  : 35;  endfunction
  function automatic int t_hmax();  return std_ntsc ? 37  : 46;  endfunction
  function automatic int t_bs();    return std_ntsc ? 38  : 47;  endfunction
  function automatic int t_blen();  return std_ntsc ? 18  : 20;  endfunction
  function automatic int t_broad(); return std_ntsc ? 179 : 221; endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one low pulse of w samples followed by g high samples; vs picks polarity (R1)
  task automatic pulse(int w, int g, bit vs, string btag);
    bit valid = (w >= t_hmin()) && (w <= t_hmax());
    bit broad = (w >= t_broad());
    bit vb0 = vb_m;
    bit vb1;
    bit eb;
    int bad_cs = -1, bad_cl = -1, bad_bg = -1, bad_vb = -1;
    int bs = t_bs(), bl = t_blen(), bm = t_broad();
    if (broad) begin vb1 = 1; run_m = 0; end
    else if (vb0) begin
      if (valid) begin
        run_m++;
        if (run_m == 4) begin vb1 = 0; run_m = 0; end else vb1 = 1;
      end else begin vb1 = 1; run_m = 0; end
    end else vb1 = 0;
    eb = valid && !vb1;
    for (int k = 0; k < w + g; k++) begin
      int j = k + 1;
      bit tgt, e_cs, e_cl, e_bg, e_vb;
      @(negedge clk);
      tgt = (k < w) ? 1'b0 : 1'b1;
      vsync_in = vs;
      hsync_in = vs ? tgt : ~tgt;
      @(posedge clk); #5;
      e_cs = !(j >= 2 && j <= w + 1);
      e_cl = (j == 2) && !vb0;
      e_bg = eb && (j >= bs + 2) && (j <= bs + bl + 1);
      if (broad)            e_vb = (j >= bm + 2) ? 1'b1 : vb0;
      else if (vb0 && !vb1) e_vb = (j >= w + 2) ? 1'b0 : 1'b1;
      else                  e_vb = vb0;
      if (csync_out    !== e_cs && bad_cs < 0) bad_cs = j;
      if (clamp_strobe !== e_cl && bad_cl < 0) bad_cl = j;
      if (burst_gate   !== e_bg && bad_bg < 0) bad_bg = j;
      if (vblank       !== e_vb && bad_vb < 0) bad_vb = j;
    end
    vb_m = vb1;
    check(bad_cs < 0, "R1", $sformatf("csync w=%0d first bad cycle", w), bad_cs, -1);
    check(bad_cl < 0, "R2", $sformatf("clamp w=%0d first bad cycle", w), bad_cl, -1);
    check(bad_bg < 0, btag, $sformatf("burst w=%0d exp_burst=%0d first bad cycle", w, eb), bad_bg, -1);
    check(bad_vb < 0, broad ? "R6" : "R7", $sformatf("vblank w=%0d first bad cycle", w), bad_vb, -1);
  endtask

  task automatic std_gap(int g);
    int w = t_hmin() + 4;
    pulse(w, g, 1'b1, "R5");
  endtask

  task automatic directed(string r8tag);
    int gap = t_bs() + t_blen() + 10;
    pulse(t_hmin() + 5, gap, 1'b1, r8tag);     // R5 nominal line sync
    pulse(t_hmin() + 5, gap, 1'b0, "R1");      // R1 inverted polarity input
    pulse(t_hmin() - 1, gap, 1'b1, "R3");      // R3 just below window
    pulse(t_hmin(),     gap, 1'b1, "R3");
    pulse(t_hmax(),     gap, 1'b0, "R3");
    pulse(t_hmax() + 1, gap, 1'b1, "R3");      // R3 just above window
    pulse(16,           gap, 1'b1, "R4");      // R4 equalizing pulse
    pulse(t_broad() - 1, gap, 1'b1, "R4");     // R6 one short of broad
    pulse(t_broad() + 3, gap, 1'b1, "R4");     // R6 sets vblank
    pulse(16,           gap, 1'b1, "R4");
    pulse(t_hmin() + 2, gap, 1'b1, "R4");
    pulse(t_hmin() + 2, gap, 1'b1, "R4");
    pulse(16,           gap, 1'b0, "R7");      // R7 restarts the run
    for (int n = 0; n < 4; n++) pulse(t_hmax(), gap, 1'b1, "R7");
    pulse(t_broad(),    gap, 1'b1, "R6");      // R6 exact threshold
    for (int n = 0; n < 4; n++) pulse(t_hmin(), gap, 1'b0, "R7");
  endtask

  task automatic random_run(int count);
    for (int n = 0; n < count; n++) begin
      int cat = $urandom % 8;
      int w;
      int g = t_bs() + t_blen() + 4 + ($urandom % 30);
      if (cat < 2)       w = 6 + ($urandom % (t_hmin() - 6));
      else if (cat < 6)  w = t_hmin() + ($urandom % (t_hmax() - t_hmin() + 1));
      else if (cat == 6) w = t_hmax() + 1 + ($urandom % (t_broad() - t_hmax() - 1));
      else               w = t_broad() + ($urandom % 30);
      pulse(w, g, 1'($urandom % 2), "R4");
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(posedge clk);
    #5;
    check(csync_out === 1'b1, "R9", "csync in reset", csync_out, 1);
    check({burst_gate, clamp_strobe, vblank} === 3'b000, "R9", "flags in reset",
          {burst_gate, clamp_strobe, vblank}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(csync_out === 1'b1 && {burst_gate, clamp_strobe, vblank} === 3'b000, "R9",
          "outputs after reset", {csync_out, burst_gate, clamp_strobe, vblank}, 8);
    directed("R8");
    random_run(150);
    std_gap(300);
    @(negedge clk); std_ntsc = 1'b0;            // R8 switch to 625-line set
    directed("R8");
    random_run(100);
    finish_up();
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end
endmodule